// File: doc/BRIEF.md
# UART Byte Queue with Status Word

This block is a synchronous byte FIFO that sits between a UART line engine and the bus side of a serial port. Bytes go in through a push strobe and come out through a pop strobe. The popped byte appears on a registered output one cycle later. A synchronous reset empties the queue. The parent block drives that reset on a line break or on a requested receiver or transmitter reset.

A 16-bit status word reports the following:
- the configured size, as a base-2 logarithm;
- the current fill level;
- two flag bits, whose meaning depends on the direction parameter `IS_RX`.

For receive use, the flags show that data is waiting and that the queue is filling up. For transmit use, they show that there is room for more data and that the queue is running low. A sticky error flag records a pop from an empty queue and a push into a full queue.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| EMPTY | No bytes held |
| PARTIAL | Between one byte and depth minus one bytes |
| FULL | All slots used |

The named transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| FILL_FIRST | EMPTY | PARTIAL | Any push |
| FILL_LAST | PARTIAL | FULL | A lone push at depth minus one |
| DRAIN_LAST | PARTIAL | EMPTY | A lone pop at a count of one |
| DRAIN_FIRST | FULL | PARTIAL | A lone pop |

A push and a pop in the same cycle keep the current state.

Top module: `uart_byte_queue`

## Requirements
- R1: The depth is 2^L entries, where L is `LOG_DEPTH` clamped to the range 2 to 10. Status bits [15:12] hold L.
- R2: While `rst` is high on a clock edge, the queue empties. After reset, `not_empty`=0, `err_flag`=0, `pop_data`=0 and the fill field is 0.
- R3: Status bits [L+1:2] hold the fill count modulo 2^L, so a full queue reads 0 there. Status bits from L+2 to 11 read 0.
- R4: With `IS_RX`=1, status bit 0 is 1 when the queue holds at least one byte. Status bit 1 is 1 when the fill count is at least 2^(L-1).
- R5: With `IS_RX`=0, status bit 0 is 1 when at least one slot is free. Status bit 1 is 1 when the fill count is below 2^(L-1).
- R6: Bytes leave in the order they were accepted. A pop accepted at edge k shows its byte on `pop_data` after edge k. `pop_data` holds that byte until the next accepted pop.
- R7: A pop while the queue is empty sets `err_flag` and leaves `pop_data` unchanged.
- R8: A push into a full queue without a pop in the same cycle drops the byte, sets `err_flag`, and leaves the status word unchanged.
- R9: `err_flag` stays at 1 until reset.
- R10: A push and a pop in the same cycle on a non-empty queue leave the fill count unchanged. This includes a full queue, where the push is accepted.
- R11: `not_empty` is 1 exactly when the fill count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties the queue |
| push_valid | input | 1 | Push strobe |
| push_data | input | DATA_W | Byte to push |
| pop_req | input | 1 | Pop strobe |
| pop_data | output | DATA_W | Registered popped byte |
| not_empty | output | 1 | Queue holds at least one byte |
| err_flag | output | 1 | Sticky underflow/overflow error |
| status | output | 16 | Size, fill count and direction flags |

## Verification
The bench pushes the queue to exactly full. There it checks that the fill field wraps to zero while the flags still mark the state. A design that sized the field wrongly would show a stale count or corrupt the size field.

An overflow push uses a marker byte. If that byte ever leaves the queue, the design stored into a full queue. The scoreboard also checks simultaneous push and pop, both at full and at mid-level. A design that refused the push at full, or that counted it twice, would lose or duplicate data.

Further checks cover:
- an empty pop, after which the output byte must not change;
- clamping of `LOG_DEPTH` from below and from above;
- a reset issued while data is held, after which no stale byte may come out.

// File: rtl/uart_q_pkg.sv
package uart_q_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    localparam int STATUS_W = 16;
    localparam int SIZE_LSB = 12;
    localparam int LG_MIN   = 2;
    localparam int LG_MAX   = 10;

    function automatic int clamp_lg(input int lg);
        if (lg < LG_MIN) return LG_MIN;
        if (lg > LG_MAX) return LG_MAX;
        return lg;
    endfunction

endpackage

// File: rtl/uq_occupancy.sv
module uq_occupancy
    import uart_q_pkg::*;
#(
    parameter int LG = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  logic        pop,
    output logic        push_ok,
    output logic        pop_ok,
    output logic [LG:0] count,
    output occ_e        state,
    output logic        err
);
    localparam int          DEPTH    = 1 << LG;
    localparam logic [LG:0] LAST_LVL = (LG+1)'(DEPTH - 1);
    localparam logic [LG:0] ONE_LVL  = (LG+1)'(1);

    occ_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OCC_EMPTY;
        else     state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = OCC_PARTIAL;               // FILL_FIRST
            end
            OCC_PARTIAL: begin
                if (push_ok && !pop_ok && count == LAST_LVL)
                    state_d = OCC_FULL;                        // FILL_LAST
                else if (pop_ok && !push_ok && count == ONE_LVL)
                    state_d = OCC_EMPTY;                       // DRAIN_LAST
            end
            OCC_FULL: begin
                if (pop_ok && !push_ok) state_d = OCC_PARTIAL; // DRAIN_FIRST
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        pop_ok  = pop && (state_q != OCC_EMPTY);
        push_ok = push && ((state_q != OCC_FULL) || pop);
        state   = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if ((pop && state_q == OCC_EMPTY) ||
                 (push && !pop && state_q == OCC_FULL))
            err <= 1'b1;
    end

endmodule

// File: rtl/uq_storage.sv
module uq_storage #(
    parameter int DW = 8,
    parameter int LG = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << LG;

    logic [DW-1:0] mem [DEPTH];
    logic [LG-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) begin
                rd_ptr  <= rd_ptr + 1'b1;
                rd_data <= mem[rd_ptr];
            end
        end
    end

endmodule

// File: rtl/uq_status.sv
module uq_status
    import uart_q_pkg::*;
#(
    parameter int LG    = 4,
    parameter bit IS_RX = 1'b1
) (
    input  logic [LG:0]         count,
    input  occ_e                state,
    output logic [STATUS_W-1:0] status
);
    localparam int HALF = 1 << (LG - 1);

    logic flag0, flag1;

    generate
        if (IS_RX) begin : g_rx
            assign flag0 = (state != OCC_EMPTY);
            assign flag1 = (count >= HALF[LG:0]);
        end else begin : g_tx
            assign flag0 = (state != OCC_FULL);
            assign flag1 = (count < HALF[LG:0]);
        end
    endgenerate

    always_comb begin
        status = '0;
        status[STATUS_W-1:SIZE_LSB] = 4'(LG);
        status[LG+1:2] = count[LG-1:0];
        status[1] = flag1;
        status[0] = flag0;
    end

endmodule

// File: rtl/uart_byte_queue.sv
module uart_byte_queue
    import uart_q_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LOG_DEPTH = 4,
    parameter bit IS_RX     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              not_empty,
    output logic              err_flag,
    output logic [15:0]       status
);
    localparam int LG_EFF = clamp_lg(LOG_DEPTH);

    logic          push_ok, pop_ok;
    logic [LG_EFF:0] count;
    occ_e          state;

    uq_occupancy #(.LG(LG_EFF)) u_occ (
        .clk(clk), .rst(rst), .push(push_valid), .pop(pop_req),
        .push_ok(push_ok), .pop_ok(pop_ok), .count(count),
        .state(state), .err(err_flag)
    );

    uq_storage #(.DW(DATA_W), .LG(LG_EFF)) u_store (
        .clk(clk), .rst(rst), .wr_en(push_ok), .wr_data(push_data),
        .rd_en(pop_ok), .rd_data(pop_data)
    );

    uq_status #(.LG(LG_EFF), .IS_RX(IS_RX)) u_stat (
        .count(count), .state(state), .status(status)
    );

    assign not_empty = (state != OCC_EMPTY);

endmodule

// File: rtl/uq_checker.sv
module uq_checker #(
    parameter int DW    = 8,
    parameter int LG    = 4,
    parameter bit IS_RX = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          push_valid,
    input logic          pop_req,
    input logic [DW-1:0] pop_data,
    input logic          not_empty,
    input logic          err_flag,
    input logic [15:0]   status
);
    logic [LG-1:0] fill_f;
    logic          full;
    assign fill_f = status[LG+1:2];
    assign full   = not_empty && (fill_f == '0);

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!not_empty && !err_flag && fill_f == '0));

    a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !not_empty) |=> (err_flag && $stable(pop_data)));

    a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !pop_req) |=> (err_flag && $stable(status)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    a_r10_level_held: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop_req && not_empty) |=> $stable(status));

    a_r11_idle_empty: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && !push_valid) |=> !not_empty);

    generate
        if (IS_RX) begin : g_rx
            a_r4_rx_bit0: assert property (@(posedge clk) disable iff (rst)
                status[0] == not_empty);
        end else begin : g_tx
            a_r5_tx_bit0: assert property (@(posedge clk) disable iff (rst)
                status[0] == !full);
        end
    endgenerate

endmodule

bind uart_byte_queue uq_checker #(.DW(DATA_W), .LG(LG_EFF), .IS_RX(IS_RX)) u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .pop_req(pop_req),
    .pop_data(pop_data), .not_empty(not_empty), .err_flag(err_flag),
    .status(status)
);

// File: tb/test_uart_byte_queue.sv
`timescale 1ns/1ps
module test_uart_byte_queue;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // receive instance: LOG_DEPTH 3, depth 8
    logic       rx_push = 0, rx_pop = 0;
    logic [7:0] rx_din = 0, rx_dout;
    logic       rx_ne, rx_err;
    logic [15:0] rx_st;

    uart_byte_queue #(.DATA_W(8), .LOG_DEPTH(3), .IS_RX(1'b1)) i_uart_byte_queue (
        .clk(clk), .rst(rst), .push_valid(rx_push), .push_data(rx_din),
        .pop_req(rx_pop), .pop_data(rx_dout), .not_empty(rx_ne),
        .err_flag(rx_err), .status(rx_st)
    );

    // transmit instance: LOG_DEPTH 1 clamps to 2, depth 4
    logic       tx_push = 0, tx_pop = 0;
    logic [7:0] tx_dout;
    logic       tx_ne, tx_err;
    logic [15:0] tx_st;

    uart_byte_queue #(.DATA_W(8), .LOG_DEPTH(1), .IS_RX(1'b0)) i_uart_byte_queue_tx (
        .clk(clk), .rst(rst), .push_valid(tx_push), .push_data(8'h11),
        .pop_req(tx_pop), .pop_data(tx_dout), .not_empty(tx_ne),
        .err_flag(tx_err), .status(tx_st)
    );

    // transmit instance: LOG_DEPTH 12 clamps to 10
    logic       bg_push = 0;
    logic [7:0] bg_dout;
    logic       bg_ne, bg_err;
    logic [15:0] bg_st;

    uart_byte_queue #(.DATA_W(8), .LOG_DEPTH(12), .IS_RX(1'b0)) i_uart_byte_queue_big (
        .clk(clk), .rst(rst), .push_valid(bg_push), .push_data(8'h22),
        .pop_req(1'b0), .pop_data(bg_dout), .not_empty(bg_ne),
        .err_flag(bg_err), .status(bg_st)
    );

    // scoreboard state
    logic [7:0] exp_q[$];
    int  mfill = 0;
    bit  merr  = 0;
    bit  pop_due_now = 0;
    bit  due_q = 0;
    logic [7:0] last_data = 8'h00;
    int  tfill = 0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat(input int lg, input bit isrx, input int fill);
        int depth = 1 << lg;
        int half  = depth / 2;
        logic [15:0] s;
        s = 16'(lg) << 12;
        s = s | (16'(fill % depth) << 2);
        if (isrx) begin
            s[0] = (fill > 0);
            s[1] = (fill >= half);
        end else begin
            s[0] = (fill < depth);
            s[1] = (fill < half);
        end
        return s;
    endfunction

    // monitor: compares popped bytes with the scoreboard queue (R6)
    always @(posedge clk) due_q <= pop_due_now;

    always @(negedge clk) begin
        if (due_q) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 actual=%h expected=<none>", rx_dout);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                last_data = e;
                if (rx_dout !== e) begin
                    errors++;
                    $display("FAIL R6 actual=%h expected=%h", rx_dout, e);
                end
            end
        end
    end

    task automatic rx_op(input bit p, input logic [7:0] d, input bit q);
        bit acc_pop, acc_push;
        @(negedge clk);
        rx_push = p; rx_din = d; rx_pop = q;
        acc_pop  = q && (mfill > 0);
        acc_push = p && ((mfill < 8) || acc_pop);
        if ((q && mfill == 0) || (p && !q && mfill == 8)) merr = 1;
        if (acc_push) exp_q.push_back(d);
        pop_due_now = acc_pop;
        mfill = mfill + int'(acc_push) - int'(acc_pop);
        @(posedge clk);
        #1;
        rx_push = 0; rx_pop = 0; pop_due_now = 0;
    endtask

    task automatic rx_expect(input string req);
        @(negedge clk);
        #0.5;
        check(req, rx_st, exp_stat(3, 1'b1, mfill));
        check("R11", {15'd0, rx_ne}, {15'd0, mfill > 0});
        check("R9", {15'd0, rx_err}, {15'd0, merr});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 0;
        mfill = 0; merr = 0; tfill = 0;
        exp_q.delete();
        last_data = 8'h00;
    endtask

    task automatic tx_op(input bit p, input bit q);
        @(negedge clk);
        tx_push = p; tx_pop = q;
        tfill = tfill + int'(p && (tfill < 4 || (q && tfill > 0))) - int'(q && tfill > 0);
        @(posedge clk);
        #1;
        tx_push = 0; tx_pop = 0;
        @(negedge clk);
        check("R5", tx_st, exp_stat(2, 1'b0, tfill));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        rx_expect("R2");
        check("R2", {8'd0, rx_dout}, 16'h0000);
        check("R1", rx_st, 16'h3000);
        check("R1", tx_st, 16'h2003);
        check("R1", bg_st, 16'hA003);

        // R7: empty pop sets the error
        rx_op(0, 8'h00, 1);
        rx_expect("R7");
        check("R7", {8'd0, rx_dout}, 16'h0000);
        repeat (3) rx_op(0, 8'h00, 0);
        rx_expect("R9");

        // R2: reset clears error
        do_reset();
        rx_expect("R2");

        // R3/R4: fill levels
        rx_op(1, 8'hA0, 0); rx_expect("R3");
        rx_op(1, 8'hA1, 0); rx_expect("R4");
        rx_op(1, 8'hA2, 0); rx_expect("R3");
        rx_op(0, 8'h00, 1); rx_expect("R6");
        for (int i = 0; i < 6; i++) begin
            rx_op(1, 8'hB0 + 8'(i), 0);
            rx_expect("R4");
        end
        check("R3", rx_st, 16'h3003);

        // R8: overflow drops the marker byte
        rx_op(1, 8'hEE, 0);
        rx_expect("R8");
        check("R8", rx_st, 16'h3003);

        // R10: simultaneous push and pop at full
        rx_op(1, 8'hC0, 1);
        rx_expect("R10");
        repeat (4) rx_op(0, 8'h00, 1);
        rx_op(1, 8'hD0, 1);
        rx_expect("R10");

        // drain; then empty pop leaves data
        while (mfill > 0) rx_op(0, 8'h00, 1);
        rx_expect("R11");
        rx_op(0, 8'h00, 1);
        rx_expect("R7");
        check("R7", {8'd0, rx_dout}, {8'd0, last_data});

        // R2: reset while holding data
        rx_op(1, 8'h71, 0);
        rx_op(1, 8'h72, 0);
        do_reset();
        rx_expect("R2");
        rx_op(1, 8'h5A, 0);
        rx_op(0, 8'h00, 1);
        rx_expect("R6");

        // R5: transmit flags, depth 4 after clamp (R1)
        tx_op(1, 0);
        tx_op(1, 0);
        tx_op(1, 0);
        tx_op(1, 0);
        check("R5", tx_st, 16'h2000);
        tx_op(0, 1);
        check("R5", tx_st, 16'h200D);

        // R1: upper clamp instance, fill field in [11:2]
        @(negedge clk);
        bg_push = 1;
        @(posedge clk);
        #1;
        bg_push = 0;
        @(negedge clk);
        check("R1", bg_st, 16'hA007);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule